// File: doc/BRIEF.md
# Port-Filtered Fabric Transaction Counter

This block counts fabric transactions of one chosen kind for an accelerator host interface. Eight transaction sources each raise a one-cycle strobe when a transaction of their kind completes. Each strobe comes with a 2-bit tag naming the port that issued it. Software writes a control word that picks one of the eight kinds. It can also limit counting to a single port. With the port filter off, the block counts the whole device. With it on, only transactions whose tag equals the programmed port are counted. The count register carries the active event code in its top nibble, so software can confirm which selection the count belongs to. A separate free-running cycle counter gives a time base for rate measurements.

The register interface is 32 bits wide. Each 64-bit register takes two accesses. Reading the low word captures the whole 64-bit value, and a later read of the high word returns the captured upper half. A new selection is taken over by a small state machine. The machine has three named states:
- ST_RUN: counting.
- ST_FROZEN: holding the count.
- ST_RETUNE: a settling window after a selection change.

The transitions are:
- ST_RUN to ST_RETUNE, and ST_FROZEN to ST_RETUNE, when event, filter or port is changed.
- ST_RUN to ST_FROZEN when the freeze bit is set.
- ST_FROZEN to ST_RUN when the freeze bit is cleared.
- ST_RETUNE to ST_RUN, or to ST_FROZEN if the freeze bit is set, when the window of `RETUNE_CYCLES` cycles expires. At that moment the new selection becomes active, the echo updates and the count clears.
- ST_RETUNE restarts its window if another change arrives during it.

Top module: `fab_traffic_counter`

## Requirements
- R1: After reset the control word reads 0. This means filter off, event code 0 and port 0. The count register reads 0 in both words.
- R2: With the filter off (control bit 23 = 0), every strobe of the active event counts once, whatever its port tag. Strobes of the other events are not counted.
- R3: With the filter on (control bit 23 = 1), a strobe counts only if its port tag equals control bits 21:20.
- R4: The event code is written in control bits 19:16. It is echoed in count-register bits 63:60, which are bits 31:28 of the high word at offset 0x2C. The echo updates exactly `RETUNE_CYCLES` cycles after the change is registered, and not earlier.
- R5: A write that changes the event code, the filter enable or the port ID clears the count on the same edge that the echo updates. A write that leaves these three fields unchanged starts no window and does not clear the count.
- R6: While control bit 8 (freeze) is set, the count holds its value.
- R7: While control bit 0 (clear) is set, the count is held at 0.
- R8: An event code above 7 is stored and reads back, but nothing is counted while it is active.
- R9: The cycle counter at offset 0x30 (low) and 0x34 (high) advances by one every clock. The clear and freeze bits do not affect it.
- R10: A read of a low word (0x28 or 0x30) captures the full 64-bit value. A following read of the matching high word returns the upper half as it was at that capture.
- R11: The count field occupies bits 59:0 of the count register. It advances by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the next edge |
| reg_addr | input | 8 | Byte offset of the 32-bit word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, held until the next read |
| evt_hit | input | 8 | One strobe per transaction kind, indexed by event code |
| evt_port | input | 16 | Port tag per strobe, two bits each, event e at bits 2e+1:2e |

## Verification
The bench builds the block with `RETUNE_CYCLES` set to 8 instead of the default of 7500. The default matches a 30 µs bound at 250 MHz. The shorter window lets the bench check the echo both before and after the selection change, along with the clearing edge, within a few dozen cycles. The remaining parameters keep their defaults: eight events, 2-bit port tags, a 60-bit count field and a 64-bit cycle counter. With these, every event index, both filter modes and the out-of-range event codes are reachable.

// File: rtl/fab_cnt_pkg.sv
package fab_cnt_pkg;

    localparam int EVT_W     = 4;   // width of the event code field
    localparam int PORT_W    = 2;   // width of the port ID field
    localparam int REG_AW    = 8;   // register byte address width
    localparam int CNT_FIELD = 60;  // count bits below the echo nibble

    // word offsets of the register window
    localparam logic [REG_AW-1:0] OFS_CTRL_LO = 8'h20;
    localparam logic [REG_AW-1:0] OFS_CTRL_HI = 8'h24;
    localparam logic [REG_AW-1:0] OFS_CNT_LO  = 8'h28;
    localparam logic [REG_AW-1:0] OFS_CNT_HI  = 8'h2C;
    localparam logic [REG_AW-1:0] OFS_CLK_LO  = 8'h30;
    localparam logic [REG_AW-1:0] OFS_CLK_HI  = 8'h34;

    // control word bit positions (decoded by software)
    localparam int B_CLR      = 0;
    localparam int B_FRZ      = 8;
    localparam int B_EVT_LSB  = 16;
    localparam int B_PORT_LSB = 20;
    localparam int B_FILT     = 23;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FROZEN = 2'd1,
        ST_RETUNE = 2'd2
    } tune_state_e;

    typedef struct packed {
        logic [EVT_W-1:0]  evt;
        logic              filt;
        logic [PORT_W-1:0] port;
    } sel_cfg_t;

endpackage

// File: rtl/fab_ctl_regs.sv
module fab_ctl_regs
    import fab_cnt_pkg::*;
#(
    parameter int CLK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [63:0]       cnt_word,
    input  logic [CLK_W-1:0]  clk_word,
    output logic              ctl_clr,
    output logic              ctl_frz,
    output sel_cfg_t          ctl_sel,
    output logic              cfg_chg
);

    sel_cfg_t    wr_sel;
    logic        wr_ctl;
    logic [63:0] clk64;
    logic [31:0] ctl_word;
    logic [31:0] hi_snap;

    assign wr_sel.evt  = wdata[B_EVT_LSB +: EVT_W];
    assign wr_sel.filt = wdata[B_FILT];
    assign wr_sel.port = wdata[B_PORT_LSB +: PORT_W];
    assign wr_ctl      = wr && (addr == OFS_CTRL_LO);
    assign clk64       = 64'(clk_word);

    always_comb begin
        ctl_word                         = '0;
        ctl_word[B_CLR]                  = ctl_clr;
        ctl_word[B_FRZ]                  = ctl_frz;
        ctl_word[B_EVT_LSB +: EVT_W]     = ctl_sel.evt;
        ctl_word[B_PORT_LSB +: PORT_W]   = ctl_sel.port;
        ctl_word[B_FILT]                 = ctl_sel.filt;
    end

    // control register; a change pulse fires only when a selection field moves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_clr <= 1'b0;
            ctl_frz <= 1'b0;
            ctl_sel <= '0;
            cfg_chg <= 1'b0;
        end else begin
            cfg_chg <= wr_ctl && (wr_sel != ctl_sel);
            if (wr_ctl) begin
                ctl_clr <= wdata[B_CLR];
                ctl_frz <= wdata[B_FRZ];
                ctl_sel <= wr_sel;
            end
        end
    end

    // read path: low-word access captures the upper half for a later read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata   <= '0;
            hi_snap <= '0;
        end else if (rd) begin
            unique case (addr)
                OFS_CTRL_LO: rdata <= ctl_word;
                OFS_CNT_LO: begin
                    rdata   <= cnt_word[31:0];
                    hi_snap <= cnt_word[63:32];
                end
                OFS_CLK_LO: begin
                    rdata   <= clk64[31:0];
                    hi_snap <= clk64[63:32];
                end
                OFS_CNT_HI,
                OFS_CLK_HI:  rdata <= hi_snap;
                default:     rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/fab_retune_fsm.sv
module fab_retune_fsm
    import fab_cnt_pkg::*;
#(
    parameter int RETUNE_CYCLES = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_chg,
    input  logic freeze,
    output logic count_en,
    output logic busy,
    output logic apply
);

    localparam int            TW     = $clog2(RETUNE_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(RETUNE_CYCLES - 1);

    tune_state_e   state;
    tune_state_e   state_nx;
    logic [TW-1:0] timer;
    logic          window_done;

    assign window_done = (timer == T_LAST) && !cfg_chg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // settle timer, restarted by every selection change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              timer <= '0;
        else if (state != ST_RETUNE || cfg_chg)  timer <= '0;
        else                                     timer <= timer + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (cfg_chg)     state_nx = ST_RETUNE;
                else if (freeze) state_nx = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (cfg_chg)      state_nx = ST_RETUNE;
                else if (!freeze) state_nx = ST_RUN;
            end
            ST_RETUNE: begin
                if (window_done) state_nx = freeze ? ST_FROZEN : ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        count_en = (state == ST_RUN);
        busy     = (state == ST_RETUNE);
        apply    = (state == ST_RETUNE) && window_done;
    end

endmodule

// File: rtl/fab_event_sel.sv
module fab_event_sel
    import fab_cnt_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic [NUM_EVT-1:0]        hit,
    input  logic [NUM_EVT*PORT_W-1:0] tags,
    input  sel_cfg_t                  sel,
    output logic                      inc
);

    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic [NUM_EVT-1:0] match;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_match
        assign match[e] = hit[e] &&
                          (!sel.filt || (tags[e*PORT_W +: PORT_W] == sel.port));
    end

    always_comb begin
        if (32'(sel.evt) < NUM_EVT) inc = match[IDX_W'(sel.evt)];
        else                        inc = 1'b0;
    end

endmodule

// File: rtl/fab_count_core.sv
module fab_count_core
    import fab_cnt_pkg::*;
#(
    parameter int CNT_W = 60,
    parameter int CLK_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  sel_cfg_t         new_sel,
    input  logic             clr,
    input  logic             count_en,
    input  logic             inc,
    output sel_cfg_t         act_sel,
    output logic [CNT_W-1:0] count,
    output logic [CLK_W-1:0] cycles
);

    // free-running time base, untouched by clear and freeze
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cycles <= '0;
        else        cycles <= cycles + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sel <= '0;
            count   <= '0;
        end else if (apply) begin
            act_sel <= new_sel;
            count   <= '0;
        end else if (clr) begin
            count   <= '0;
        end else if (count_en && inc) begin
            count   <= count + 1'b1;
        end
    end

endmodule

// File: rtl/fab_traffic_counter.sv
module fab_traffic_counter
    import fab_cnt_pkg::*;
#(
    parameter int NUM_EVT       = 8,
    parameter int CNT_W         = 60,
    parameter int CLK_W         = 64,
    parameter int RETUNE_CYCLES = 7500
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic [NUM_EVT-1:0]          evt_hit,
    input  logic [NUM_EVT*PORT_W-1:0]   evt_port
);

    logic             ctl_clr;
    logic             ctl_frz;
    sel_cfg_t         ctl_sel;
    logic             cfg_chg;
    logic             count_en;
    logic             retune_busy;
    logic             apply_cfg;
    logic             inc;
    sel_cfg_t         act_sel;
    logic [CNT_W-1:0] cnt_val;
    logic [CLK_W-1:0] clk_val;
    logic [EVT_W-1:0] echo_evt;
    logic [63:0]      cnt_word;

    assign echo_evt = act_sel.evt;
    assign cnt_word = {echo_evt, CNT_FIELD'(cnt_val)};

    fab_ctl_regs #(.CLK_W(CLK_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cnt_word (cnt_word),
        .clk_word (clk_val),
        .ctl_clr  (ctl_clr),
        .ctl_frz  (ctl_frz),
        .ctl_sel  (ctl_sel),
        .cfg_chg  (cfg_chg)
    );

    fab_retune_fsm #(.RETUNE_CYCLES(RETUNE_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_chg  (cfg_chg),
        .freeze   (ctl_frz),
        .count_en (count_en),
        .busy     (retune_busy),
        .apply    (apply_cfg)
    );

    fab_event_sel #(.NUM_EVT(NUM_EVT)) u_sel (
        .hit  (evt_hit),
        .tags (evt_port),
        .sel  (act_sel),
        .inc  (inc)
    );

    fab_count_core #(.CNT_W(CNT_W), .CLK_W(CLK_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (apply_cfg),
        .new_sel  (ctl_sel),
        .clr      (ctl_clr),
        .count_en (count_en),
        .inc      (inc),
        .act_sel  (act_sel),
        .count    (cnt_val),
        .cycles   (clk_val)
    );

endmodule

// File: rtl/fab_traffic_counter_chk.sv
module fab_traffic_counter_chk #(
    parameter int CNT_W         = 60,
    parameter int CLK_W         = 64,
    parameter int RETUNE_CYCLES = 7500
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic [3:0]       echo,
    input logic [CLK_W-1:0] cycles,
    input logic             count_en,
    input logic             busy,
    input logic             clr,
    input logic             cfg_chg
);

    localparam int WW = $clog2(RETUNE_CYCLES + 2) + 1;

    logic [WW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wait_cnt <= '0;
        else if (!busy || cfg_chg)  wait_cnt <= '0;
        else                        wait_cnt <= wait_cnt + 1'b1;
    end

    AST_CLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cycles == $past(cycles) + 1'b1); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count == $past(count) || count == $past(count) + 1'b1 || count == '0)); // R11

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(count_en)) |-> (count == $past(count) || count == '0)); // R6

    AST_BAD_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(echo) > 4'd7) |-> (count == $past(count) || count == '0)); // R8

    AST_ECHO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(echo)) |-> count == '0); // R5

    AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R7

    AST_RETUNE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> 32'(wait_cnt) <= RETUNE_CYCLES); // R4

endmodule

bind fab_traffic_counter fab_traffic_counter_chk #(
    .CNT_W         (CNT_W),
    .CLK_W         (CLK_W),
    .RETUNE_CYCLES (RETUNE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (cnt_val),
    .echo     (echo_evt),
    .cycles   (clk_val),
    .count_en (count_en),
    .busy     (retune_busy),
    .clr      (ctl_clr),
    .cfg_chg  (cfg_chg)
);

// File: tb/fab_traffic_counter_test.sv
`timescale 1ns/1ps
module fab_traffic_counter_test;

    localparam int RETUNE = 8;
    localparam int NEVT   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_hit = '0;
    logic [15:0] evt_port = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fab_traffic_counter #(.RETUNE_CYCLES(RETUNE)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_hit   (evt_hit),
        .evt_port  (evt_port)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // n cycles of a strobe on event e with port tag p
    task automatic pulse(input int e, input logic [1:0] p, input int n);
        for (int i = 0; i < n; i++) begin
            evt_hit = '0;
            evt_hit[e] = 1'b1;
            evt_port = '0;
            evt_port[e*2 +: 2] = p;
            @(negedge clk);
        end
        evt_hit = '0;
        evt_port = '0;
    endtask

    task automatic settle();
        idle(RETUNE + 4);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(8'h20, v); check("R1 ctrl after reset", v, 32'h0);
        rd_reg(8'h28, v); check("R1 count low after reset", v, 32'h0);
        rd_reg(8'h2C, v); check("R1 count high after reset", v, 32'h0);
    endtask

    task automatic t_unfiltered();
        logic [31:0] v;
        pulse(0, 2'd0, 3);
        pulse(0, 2'd2, 2);
        pulse(1, 2'd0, 4);
        rd_reg(8'h28, v); check("R2 all ports counted, other event ignored", v, 32'd5);
    endtask

    task automatic t_retune();
        logic [31:0] v;
        wr_reg(8'h20, 32'h0005_0000);
        rd_reg(8'h28, v); check("R5 count kept before window ends", v, 32'd5);
        rd_reg(8'h2C, v); check("R4 echo still old before window ends", v, 32'h0);
        settle();
        rd_reg(8'h28, v); check("R5 count cleared at echo update", v, 32'd0);
        rd_reg(8'h2C, v); check("R4 echo shows new event", v, 32'h5000_0000);
    endtask

    task automatic t_filter();
        logic [31:0] v;
        wr_reg(8'h20, 32'h00A5_0000);
        settle();
        pulse(5, 2'd2, 3);
        pulse(5, 2'd1, 4);
        pulse(5, 2'd3, 2);
        rd_reg(8'h28, v); check("R3 only port 2 counted", v, 32'd3);
        wr_reg(8'h20, 32'h0095_0000);
        settle();
        rd_reg(8'h28, v); check("R5 port change clears count", v, 32'd0);
        pulse(5, 2'd1, 2);
        pulse(5, 2'd2, 3);
        rd_reg(8'h28, v); check("R3 only port 1 counted", v, 32'd2);
        rd_reg(8'h20, v); check("R3 ctrl readback", v, 32'h0095_0000);
    endtask

    task automatic t_same_write();
        logic [31:0] v;
        wr_reg(8'h20, 32'h0095_0000);
        settle();
        rd_reg(8'h28, v); check("R5 unchanged selection keeps count", v, 32'd2);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        wr_reg(8'h20, 32'h0095_0100);
        idle(3);
        pulse(5, 2'd1, 4);
        rd_reg(8'h28, v); check("R6 frozen count held", v, 32'd2);
        wr_reg(8'h20, 32'h0095_0000);
        idle(3);
        pulse(5, 2'd1, 1);
        rd_reg(8'h28, v); check("R6 counting resumes", v, 32'd3);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr_reg(8'h20, 32'h0095_0001);
        idle(2);
        pulse(5, 2'd1, 3);
        rd_reg(8'h28, v); check("R7 clear holds zero", v, 32'd0);
        wr_reg(8'h20, 32'h0095_0000);
        pulse(5, 2'd1, 2);
        rd_reg(8'h28, v); check("R7 counts after clear removed", v, 32'd2);
    endtask

    task automatic t_clock();
        logic [31:0] a;
        logic [31:0] b;
        wr_reg(8'h20, 32'h0095_0101);
        rd_reg(8'h30, a);
        idle(10);
        rd_reg(8'h30, b);
        check("R9 cycle counter step with clear and freeze set", b - a, 32'd11);
        rd_reg(8'h34, b); check("R9 cycle counter high word", b, 32'h0);
        wr_reg(8'h20, 32'h0095_0000);
    endtask

    task automatic t_bad_event();
        logic [31:0] v;
        wr_reg(8'h20, 32'h000C_0000);
        settle();
        rd_reg(8'h20, v); check("R8 out-of-range code stored", v, 32'h000C_0000);
        for (int e = 0; e < NEVT; e++) pulse(e, 2'(e), 2);
        rd_reg(8'h28, v); check("R8 nothing counted", v, 32'd0);
        rd_reg(8'h2C, v); check("R8 echo of code 0xC", v, 32'hC000_0000);
    endtask

    task automatic t_snapshot();
        logic [31:0] v;
        wr_reg(8'h20, 32'h0003_0000);
        settle();
        pulse(3, 2'd0, 6);
        rd_reg(8'h28, v); check("R10 low word at capture", v, 32'd6);
        wr_reg(8'h20, 32'h0006_0000);
        settle();
        rd_reg(8'h2C, v); check("R10 high word from capture", v, 32'h3000_0000);
        rd_reg(8'h28, v); check("R10 new low word", v, 32'd0);
        rd_reg(8'h2C, v); check("R10 new high word", v, 32'h6000_0000);
    endtask

    task automatic t_wide_count();
        logic [31:0] v;
        pulse(6, 2'd3, 9);
        rd_reg(8'h28, v); check("R11 one per cycle", v, 32'd9);
        rd_reg(8'h2C, v); check("R11 echo above count field", v, 32'h6000_0000);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_unfiltered();
        t_retune();
        t_filter();
        t_same_write();
        t_freeze();
        t_clear();
        t_clock();
        t_bad_event();
        t_snapshot();
        t_wide_count();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..) actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule